// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block fills a device's configuration registers from a 1 Kbit serial EEPROM organised as 64 sixteen-bit words. It drives the EEPROM over a four-wire Microwire-style link (select, clock, data out, data in). It fetches words one at a time in ascending address order, starting at word 0. Each fetched byte is then turned into register write strobes that carry a target code, a 16-bit data value and a 16-bit lane mask.

A load starts by itself on the first cycle after the synchronous reset is released. Software can also start one with a one-cycle command pulse while the block is idle. Word 0 must hold a fixed signature. If it does not, the load ends at once with a fail indication, and no register is written. When the signature matches, the block walks bytes 06h to 15h. Subsystem IDs, bus timer values, six station address bytes and three configuration bytes are delivered as plain byte writes. One media/control byte is split across three registers, and one of its bits is inverted on the way. The vendor and device identifiers are never loaded and are presented as constants.

Top module: `cfg_autoload`

## Requirements
- R1: A load starts in the cycle after reset is released, and again on an `sw_load` pulse while idle. `busy` is high from the cycle after the start until `done`, `done` is a single-cycle pulse with `pass` valid in the same cycle, and `busy` is low in the cycle after `done`.
- R2: Each word read holds `ee_cs` high and sends, on `ee_di`, the bits 1, 1, 0 and then the 6-bit word address MSB first. Each bit is valid at the rising edge of `ee_sk`. `ee_sk` stays low while `ee_cs` is low. Words are read in order 0, 1, 2 and so on up to word 10. `ee_cs` stays low for at least one full serial clock period between reads.
- R3: `ee_do` is sampled at the end of each `ee_sk` high phase. The bit of the tenth serial cycle (the dummy bit) is discarded, and the following 16 bits form the word MSB first. The even byte address is the low byte of each word, so byte 00h holds 29h and byte 01h holds 81h when the signature is correct.
- R4: If word 0 is not 8129h, `done` pulses with `pass` = 0, no write strobe is issued and no further word is read. Otherwise `pass` = 1 at the end of the load.
- R5: Bytes 06h/07h go to subsystem vendor ID (target 0) and bytes 08h/09h go to subsystem ID (target 1). The low byte is written as data {00h,b} with mask 00FFh, and the high byte as data {b,00h} with mask FF00h.
- R6: Byte 0Ah goes to the minimum-grant register (target 2) and byte 0Bh to the maximum-latency register (target 3), each as data {00h,b} with mask 00FFh.
- R7: Bytes 0Eh..13h are written in order to station address bytes 0..5 (targets 8..13), each as data {00h,b} with mask 00FFh.
- R8: Byte 0Ch produces a media status write (target 4) that carries its bits 7..6 in bits 7..6 with mask 00C0h. It then produces a basic-mode-control write (target 5) that carries its bits 5, 4 and 0 in bits 13, 12 and 8 with mask 3100h. Its bits 3..2 reach no register.
- R9: After those two writes, byte 0Ch produces an advertisement write (target 6) whose bit 10 is the inverse of byte bit 1, with mask 0400h.
- R10: Bytes 0Dh, 14h and 15h go to configuration registers 3, 0 and 1 (targets 7, 14, 15), each as data {00h,b} with mask 00FFh. All writes of a load come in ascending byte address order, and bytes 00h..05h produce no write.
- R11: `vendor_id` is 10ECh and `device_id` is 8139h at all times, independent of the EEPROM contents.
- R12: An `sw_load` pulse that arrives while `busy` is high is discarded. No further read or `done` follows the current load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_load | input | 1 | Software load command pulse |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 4 | Target register code |
| wr_data | output | 16 | Write data |
| wr_mask | output | 16 | Bit lanes that the write updates |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| pass | output | 1 | Signature result, valid with done |
| vendor_id | output | 16 | Fixed vendor identifier |
| device_id | output | 16 | Fixed device identifier |

## Verification
The EEPROM model leaves its data line high and returns a 0 dummy bit. A reader that kept the dummy bit would shift every word by one place, and every later comparison would fail. Two bad signatures are tried. One is off by a single bit. The other has its bytes swapped, which catches a design that swaps byte order within a word. A design that writes anything on a mismatch, or keeps reading, shows up as an unexpected write or as extra frames. The split byte is exercised with two opposite bit patterns in which the ignored bits are set. A design that leaks bits 3..2 into a register, fails to invert the advertisement bit, or gets the order of the three writes wrong fails the scoreboard. A command pulse issued in the middle of a load must not cause a second run.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;

    localparam int          WORD_W      = 16;
    localparam int          ADDR_W      = 6;
    localparam int          BYTE_AW     = ADDR_W + 1;
    localparam int          SUBS        = 3;
    localparam logic [15:0] SIGNATURE   = 16'h8129;
    localparam logic [15:0] FIXED_VID   = 16'h10EC;
    localparam logic [15:0] FIXED_DID   = 16'h8139;

    typedef enum logic [3:0] {
        TGT_SVID   = 4'd0,
        TGT_SSID   = 4'd1,
        TGT_MINGNT = 4'd2,
        TGT_MAXLAT = 4'd3,
        TGT_MEDIA  = 4'd4,
        TGT_BMCTL  = 4'd5,
        TGT_ANADV  = 4'd6,
        TGT_CFG3   = 4'd7,
        TGT_STA0   = 4'd8,
        TGT_STA1   = 4'd9,
        TGT_STA2   = 4'd10,
        TGT_STA3   = 4'd11,
        TGT_STA4   = 4'd12,
        TGT_STA5   = 4'd13,
        TGT_CFG0   = 4'd14,
        TGT_CFG1   = 4'd15
    } tgt_e;

    typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_state_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_READ, SQ_SCAT, SQ_FIN} sq_state_e;

    typedef struct packed {
        logic        valid;
        tgt_e        tgt;
        logic [15:0] data;
        logic [15:0] mask;
    } wr_item_t;

    function automatic wr_item_t make_item(tgt_e t, logic [15:0] d, logic [15:0] m);
        return '{1'b1, t, d, m};
    endfunction

    function automatic wr_item_t low_lane(tgt_e t, logic [7:0] b);
        return make_item(t, {8'h00, b}, 16'h00FF);
    endfunction

    function automatic wr_item_t high_lane(tgt_e t, logic [7:0] b);
        return make_item(t, {b, 8'h00}, 16'hFF00);
    endfunction

    // Map one fetched byte and one sub-slot to at most one register write.
    function automatic wr_item_t map_byte(logic [BYTE_AW-1:0] ba, logic [7:0] b, logic [1:0] sub);
        wr_item_t it;
        it = '{1'b0, TGT_SVID, 16'h0000, 16'h0000};
        if (sub == 2'd0) begin
            case (ba)
                7'h06: it = low_lane(TGT_SVID, b);
                7'h07: it = high_lane(TGT_SVID, b);
                7'h08: it = low_lane(TGT_SSID, b);
                7'h09: it = high_lane(TGT_SSID, b);
                7'h0A: it = low_lane(TGT_MINGNT, b);
                7'h0B: it = low_lane(TGT_MAXLAT, b);
                7'h0C: it = make_item(TGT_MEDIA, {8'h00, b[7:6], 6'b000000}, 16'h00C0);
                7'h0D: it = low_lane(TGT_CFG3, b);
                7'h0E, 7'h0F, 7'h10, 7'h11, 7'h12, 7'h13:
                       it = low_lane(tgt_e'(4'(ba[3:0] + 4'd10)), b);
                7'h14: it = low_lane(TGT_CFG0, b);
                7'h15: it = low_lane(TGT_CFG1, b);
                default: ;
            endcase
        end else if (ba == 7'h0C) begin
            if (sub == 2'd1)
                it = make_item(TGT_BMCTL, {2'b00, b[5], b[4], 3'b000, b[0], 8'h00}, 16'h3100);
            else if (sub == 2'd2)
                it = make_item(TGT_ANADV, {5'b00000, ~b[1], 10'b0}, 16'h0400);
        end
        return it;
    endfunction

endpackage

// File: rtl/mw_word_reader.sv
module mw_word_reader
    import cfg_autoload_pkg::*;
#(
    parameter int HALF_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              idle,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int CMD_W      = 3 + ADDR_W;
    localparam int DATA_FIRST = CMD_W + 1;
    localparam int FRAME      = DATA_FIRST + WORD_W;
    localparam int GAP_CLKS   = 2 * HALF_CLKS;
    localparam int PH_W       = $clog2(HALF_CLKS + 1);
    localparam int GAP_W      = $clog2(GAP_CLKS + 1);
    localparam int BIT_W      = $clog2(FRAME + 1);

    rd_state_e         st;
    logic [PH_W-1:0]   ph;
    logic              hi;
    logic [BIT_W-1:0]  bitn;
    logic [GAP_W-1:0]  gap;
    logic [CMD_W-1:0]  cmd_sr;
    logic [WORD_W-1:0] sh;
    logic              cs_q, sk_q, valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RD_IDLE;
            ph      <= '0;
            hi      <= 1'b0;
            bitn    <= '0;
            gap     <= '0;
            cmd_sr  <= '0;
            sh      <= '0;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (st)
                RD_IDLE: begin
                    if (req) begin
                        st     <= RD_SHIFT;
                        cs_q   <= 1'b1;
                        cmd_sr <= {3'b110, addr};
                        ph     <= '0;
                        hi     <= 1'b0;
                        bitn   <= '0;
                    end
                end
                RD_SHIFT: begin
                    if (ph == PH_W'(HALF_CLKS - 1)) begin
                        ph <= '0;
                        if (!hi) begin
                            hi   <= 1'b1;
                            sk_q <= 1'b1;
                        end else begin
                            hi     <= 1'b0;
                            sk_q   <= 1'b0;
                            cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
                            if (bitn >= BIT_W'(DATA_FIRST))
                                sh <= {sh[WORD_W-2:0], ee_do};
                            if (bitn == BIT_W'(FRAME - 1)) begin
                                cs_q    <= 1'b0;
                                valid_q <= 1'b1;
                                gap     <= '0;
                                st      <= RD_GAP;
                            end else begin
                                bitn <= bitn + BIT_W'(1);
                            end
                        end
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
                RD_GAP: begin
                    if (gap == GAP_W'(GAP_CLKS - 1))
                        st <= RD_IDLE;
                    else
                        gap <= gap + GAP_W'(1);
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    assign idle       = (st == RD_IDLE);
    assign word_valid = valid_q;
    assign word       = sh;
    assign ee_cs      = cs_q;
    assign ee_sk      = sk_q;
    assign ee_di      = cmd_sr[CMD_W-1];

    a_r2_clock_only_selected: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_sk);
    a_r2_gap_deselected: assert property (@(posedge clk) disable iff (rst)
        (st == RD_GAP) |-> !ee_cs);
    a_r3_word_ends_frame: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (!ee_cs && $past(st == RD_SHIFT)));

endmodule

// File: rtl/cfg_scatter_seq.sv
module cfg_scatter_seq
    import cfg_autoload_pkg::*;
#(
    parameter int LAST_WORD = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_load,
    input  logic              rd_idle,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_word,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [3:0]        wr_sel,
    output logic [15:0]       wr_data,
    output logic [15:0]       wr_mask,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    localparam int SLOT_W    = $clog2(2 * SUBS);
    localparam int SLOT_LAST = 2 * SUBS - 1;

    sq_state_e          st;
    logic               pend_q, req_q, pass_q;
    logic [ADDR_W-1:0]  idx;
    logic [WORD_W-1:0]  word_q;
    logic [SLOT_W-1:0]  slot;
    logic               wr_en_q;
    tgt_e               wr_sel_q;
    logic [15:0]        wr_data_q, wr_mask_q;

    logic               hi_byte;
    logic [BYTE_AW-1:0] baddr;
    logic [7:0]         bval;
    logic [1:0]         bsub;
    wr_item_t           item;

    assign hi_byte = (slot >= SLOT_W'(SUBS));
    assign baddr   = {idx, hi_byte};
    assign bval    = hi_byte ? word_q[15:8] : word_q[7:0];
    assign bsub    = hi_byte ? 2'(slot - SLOT_W'(SUBS)) : 2'(slot);
    assign item    = map_byte(baddr, bval, bsub);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            pend_q    <= 1'b1;
            req_q     <= 1'b0;
            pass_q    <= 1'b0;
            idx       <= '0;
            word_q    <= '0;
            slot      <= '0;
            wr_en_q   <= 1'b0;
            wr_sel_q  <= TGT_SVID;
            wr_data_q <= '0;
            wr_mask_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (req_q && rd_idle)
                req_q <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (pend_q || sw_load) begin
                        pend_q <= 1'b0;
                        idx    <= '0;
                        pass_q <= 1'b0;
                        req_q  <= 1'b1;
                        st     <= SQ_READ;
                    end
                end
                SQ_READ: begin
                    if (rd_valid) begin
                        word_q <= rd_word;
                        if (idx == '0) begin
                            if (rd_word == SIGNATURE) begin
                                idx   <= ADDR_W'(1);
                                req_q <= 1'b1;
                            end else begin
                                pass_q <= 1'b0;
                                st     <= SQ_FIN;
                            end
                        end else begin
                            slot <= '0;
                            st   <= SQ_SCAT;
                        end
                    end
                end
                SQ_SCAT: begin
                    wr_en_q   <= item.valid;
                    wr_sel_q  <= item.tgt;
                    wr_data_q <= item.data;
                    wr_mask_q <= item.mask;
                    if (slot == SLOT_W'(SLOT_LAST)) begin
                        if (idx == ADDR_W'(LAST_WORD)) begin
                            pass_q <= 1'b1;
                            st     <= SQ_FIN;
                        end else begin
                            idx   <= idx + ADDR_W'(1);
                            req_q <= 1'b1;
                            st    <= SQ_READ;
                        end
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end
                SQ_FIN:  st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign rd_req  = req_q;
    assign rd_addr = idx;
    assign wr_en   = wr_en_q;
    assign wr_sel  = wr_sel_q;
    assign wr_data = wr_data_q;
    assign wr_mask = wr_mask_q;
    assign busy    = (st != SQ_IDLE);
    assign done    = (st == SQ_FIN);
    assign pass    = pass_q;

    a_r1_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    a_r1_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
    a_r4_fail_writes_nothing: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> !wr_en);
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr <= ADDR_W'(LAST_WORD)));

endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
    import cfg_autoload_pkg::*;
#(
    parameter int HALF_CLKS = 2,
    parameter int LAST_WORD = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_load,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do,
    output logic        wr_en,
    output logic [3:0]  wr_sel,
    output logic [15:0] wr_data,
    output logic [15:0] wr_mask,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic [15:0] vendor_id,
    output logic [15:0] device_id
);
    logic              rd_req, rd_idle, rd_valid;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;

    mw_word_reader #(.HALF_CLKS(HALF_CLKS)) u_reader (
        .clk        (clk),
        .rst        (rst),
        .req        (rd_req),
        .addr       (rd_addr),
        .idle       (rd_idle),
        .word_valid (rd_valid),
        .word       (rd_word),
        .ee_cs      (ee_cs),
        .ee_sk      (ee_sk),
        .ee_di      (ee_di),
        .ee_do      (ee_do)
    );

    cfg_scatter_seq #(.LAST_WORD(LAST_WORD)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .sw_load  (sw_load),
        .rd_idle  (rd_idle),
        .rd_valid (rd_valid),
        .rd_word  (rd_word),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .busy     (busy),
        .done     (done),
        .pass     (pass)
    );

    assign vendor_id = FIXED_VID;
    assign device_id = FIXED_DID;

endmodule

// File: tb/tb_cfg_autoload.sv
module tb_cfg_autoload;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst, sw_load, ee_do;
    logic ee_cs, ee_sk, ee_di, wr_en, busy, done, pass;
    logic [3:0]  wr_sel;
    logic [15:0] wr_data, wr_mask, vendor_id, device_id;

    always #10 clk = ~clk;

    cfg_autoload #(.HALF_CLKS(HALF)) dut (
        .clk(clk), .rst(rst), .sw_load(sw_load),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_mask(wr_mask),
        .busy(busy), .done(done), .pass(pass),
        .vendor_id(vendor_id), .device_id(device_id)
    );

    int checks = 0, errors = 0, done_cnt = 0, gap_bad = 0, low_cnt = 0, k = 0;
    bit finished = 0, last_pass;
    logic [15:0] mem [64];
    logic [8:0]  cmd;
    logic [8:0]  frames [$];
    logic [35:0] exp_q [$];

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] s);
        if (s <= 4'd1) return "R5";
        if (s <= 4'd3) return "R6";
        if (s == 4'd4 || s == 4'd5) return "R8";
        if (s == 4'd6) return "R9";
        if (s >= 4'd8 && s <= 4'd13) return "R7";
        return "R10";
    endfunction

    // EEPROM model: idle data line high, dummy bit 0, data MSB first.
    always @(posedge ee_cs) k = 0;
    always @(posedge ee_sk) if (ee_cs) begin
        if (k < 9) cmd = {cmd[7:0], ee_di};
        if (k == 8) frames.push_back(cmd);
        if (k == 9) ee_do = 1'b0;
        else if (k >= 10 && k <= 25) ee_do = mem[cmd[5:0]][25 - k];
        k++;
    end
    always @(negedge ee_cs) ee_do = 1'b1;

    always @(negedge clk) low_cnt = ee_cs ? 0 : low_cnt + 1;
    always @(posedge ee_cs) if (low_cnt < 2 * HALF) gap_bad++;

    // Monitor: compare every strobe against the queue head.
    always @(negedge clk) if (!rst) begin
        if (wr_en) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected write", {12'h0, wr_sel, wr_data}, 32'h0);
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                chk({wr_sel, wr_data, wr_mask} == e, tag_of(e[35:32]), "write sel/data/mask",
                    {wr_sel, wr_data, wr_mask[11:0]}, {e[35:32], e[31:16], e[11:0]});
            end
        end
        if (done) begin
            done_cnt++;
            last_pass = pass;
        end
    end

    function automatic logic [7:0] ebyte(int a);
        return a[0] ? mem[a >> 1][15:8] : mem[a >> 1][7:0];
    endfunction

    task automatic push(logic [3:0] s, logic [15:0] d, logic [15:0] m);
        exp_q.push_back({s, d, m});
    endtask

    // Driver side: expected write stream built from the requirements.
    task automatic build_expected();
        exp_q.delete();
        for (int a = 6; a <= 21; a++) begin
            logic [7:0] b;
            b = ebyte(a);
            if (a == 6 || a == 8)       push(a == 6 ? 4'd0 : 4'd1, {8'h00, b}, 16'h00FF);
            else if (a == 7 || a == 9)  push(a == 7 ? 4'd0 : 4'd1, {b, 8'h00}, 16'hFF00);
            else if (a == 10)           push(4'd2, {8'h00, b}, 16'h00FF);
            else if (a == 11)           push(4'd3, {8'h00, b}, 16'h00FF);
            else if (a == 12) begin
                push(4'd4, {8'h00, b[7], b[6], 6'd0}, 16'h00C0);
                push(4'd5, (16'(b[5]) << 13) | (16'(b[4]) << 12) | (16'(b[0]) << 8), 16'h3100);
                push(4'd6, b[1] ? 16'h0000 : 16'h0400, 16'h0400);
            end
            else if (a == 13)           push(4'd7, {8'h00, b}, 16'h00FF);
            else if (a >= 14 && a <= 19) push(4'(a - 6), {8'h00, b}, 16'h00FF);
            else if (a == 20)           push(4'd14, {8'h00, b}, 16'h00FF);
            else                        push(4'd15, {8'h00, b}, 16'h00FF);
        end
    endtask

    task automatic wait_done();
        while (done_cnt == 0) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy low after done", 32'(busy), 32'h0);
    endtask

    task automatic check_frames(int n);
        bit ok = (frames.size() == n);
        for (int i = 0; i < frames.size(); i++)
            if (frames[i] != {3'b110, 6'(i)}) ok = 0;
        chk(ok, "R2", "frame count/opcode/ascending address", 32'(frames.size()), 32'(n));
    endtask

    task automatic pulse_load();
        frames.delete();
        done_cnt = 0;
        @(negedge clk) sw_load = 1'b1;
        @(negedge clk) sw_load = 1'b0;
        chk(busy == 1'b1, "R1", "busy after command", 32'(busy), 32'h1);
    endtask

    task automatic image_a();
        foreach (mem[i]) mem[i] = 16'hFFFF;
        mem[0] = 16'h8129; mem[3] = 16'h1234; mem[4] = 16'h5678; mem[5] = 16'h4020;
        mem[6] = 16'h5ACD; mem[7] = 16'h1100; mem[8] = 16'h3322; mem[9] = 16'h5544;
        mem[10] = 16'h7E81;
    endtask

    task automatic image_b();
        foreach (mem[i]) mem[i] = 16'h0000;
        mem[0] = 16'h8129; mem[1] = 16'hA5A5; mem[2] = 16'h5A5A; mem[3] = 16'hBEEF;
        mem[4] = 16'hCAFE; mem[5] = 16'hFF00; mem[6] = 16'hA53E; mem[7] = 16'h0201;
        mem[8] = 16'h0C0B; mem[9] = 16'hF0E0; mem[10] = 16'h1800;
    endtask

    initial begin
        rst = 1'b1; sw_load = 1'b0; ee_do = 1'b1; cmd = '0;
        image_a();
        build_expected();
        repeat (4) @(negedge clk);
        chk(!busy && !done && !wr_en && !ee_cs, "R1", "reset state",
            {28'h0, busy, done, wr_en, ee_cs}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R1", "auto start after reset", 32'(busy), 32'h1);
        repeat (400) @(negedge clk);
        sw_load = 1'b1;                        // R12: command while busy
        @(negedge clk) sw_load = 1'b0;
        wait_done();
        chk(last_pass == 1'b1, "R4", "pass on good signature", 32'(last_pass), 32'h1);
        chk(exp_q.size() == 0, "R10", "all writes seen", 32'(exp_q.size()), 32'h0);
        check_frames(11);
        repeat (300) @(negedge clk);
        chk(frames.size() == 11 && !busy && done_cnt == 1, "R12", "no rerun from busy command",
            32'(frames.size()), 32'd11);

        image_b();                              // inverse pattern on the split byte
        build_expected();
        pulse_load();
        wait_done();
        chk(last_pass == 1'b1, "R9", "pass with flow-control bit set", 32'(last_pass), 32'h1);
        chk(exp_q.size() == 0, "R8", "all writes seen", 32'(exp_q.size()), 32'h0);
        check_frames(11);

        mem[0] = 16'h8128;                      // one bit off
        exp_q.delete();
        pulse_load();
        wait_done();
        chk(last_pass == 1'b0, "R4", "fail on bad signature", 32'(last_pass), 32'h0);
        check_frames(1);

        mem[0] = 16'h2981;                      // byte order swapped
        pulse_load();
        wait_done();
        chk(last_pass == 1'b0, "R3", "swapped signature rejected", 32'(last_pass), 32'h0);
        check_frames(1);

        chk(vendor_id == 16'h10EC, "R11", "vendor id", 32'(vendor_id), 32'h10EC);
        chk(device_id == 16'h8139, "R11", "device id", 32'(device_id), 32'h8139);
        chk(gap_bad == 0, "R2", "deselect gap", 32'(gap_bad), 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule